// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block is the serial engine inside an SPI master. It takes 32-bit words from a transmit queue and exchanges each of them with a byte-wide serial shifter, lowest byte first. The bytes it receives back are packed into a 32-bit word, which is offered to a receive queue. One burst is a run of bits whose length is programmed through a length field. A burst can cover several queue words. A word that is only partly covered sends just the bytes that the remaining count needs.

The engine starts in one of two ways. In immediate mode it starts when a word is accepted into the transmit queue, or when the mode is turned on while words are already waiting. In request mode it starts when software changes the exchange-request bit from 0 to 1. A per-channel option selects continuous operation: the exchange request stays asserted and the engine runs through burst boundaries until the queue is empty. Outside continuous operation the engine stops at every burst end. Four active-low chip selects follow the channel-select and channel-role inputs. A sticky completion flag and a sticky overflow flag report the outcome to the surrounding register logic.

Both queues sit outside the block. The transmit queue shows its head word together with an empty flag. The receive queue reports a full flag.

Top module: `spi_burst_engine`

## Requirements
- R1: A burst holds `burst_field + 1` bits. The remaining count is reloaded from the field only when a word is fetched and the count is zero or negative. Otherwise the count carries over from the previous word.
- R2: Each fetched word sends ceil(min(remaining, 32) / 8) bytes. Byte 0 is bits 7:0, and the word shifts right by 8 after each byte. `bx_tx` is held stable while `bx_valid` is high and `bx_ready` is low. The engine pops a word only when the transmit queue is non-empty.
- R3: The k-th byte returned on `bx_rdata` (k counted from 0) lands in bits 8k+7:8k of `rx_word`, and the unused upper bits are zero. The engine waits for `bx_rvalid` before it offers the next byte. The remaining count drops by 8 for each byte, so it can go negative.
- R4: If `rx_full` is high when a word completes, the word is not pushed and `ovf_flag` is set. `ovf_flag` stays set until `ovf_clr` is pulsed.
- R5: Immediate mode (`imm_mode`=1) starts the engine on two events, each only if the selected channel is master: a pulse on `tx_wr_evt`, or a 0-to-1 change of `imm_mode` while the transmit queue is non-empty.
- R6: With `imm_mode`=0, a write of 1 to the exchange bit while that bit is 0 starts the engine, provided the selected channel is master. Any other write only stores the value into `xch_bit`.
- R7: Continuous mode means: the channel is master, `imm_mode`=0, and `cont_en[chan_sel]`=1. In this mode every burst reload forces `xch_bit` to 1, and the engine keeps going past burst ends.
- R8: Outside continuous mode, the end of a burst sets `tc_flag` and stops the engine. Words left in the transmit queue stay there, and `xch_bit` keeps its value.
- R9: When the engine finds or leaves the transmit queue empty, it sets `tc_flag`, clears `xch_bit` and stops.
- R10: When `chan_master[chan_sel]`=1, `cs_n[chan_sel]` is 0 and every other select is 1. When that bit is 0, all selects are 1 and no start is possible.
- R11: If a start event arrives in the same cycle that the engine stops, the engine goes straight on to fetch another word and the event is not lost.
- R12: After reset the engine is idle, and `tc_flag`, `ovf_flag` and `xch_bit` are 0. `tc_clr` clears `tc_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | SEL_W | Selected channel |
| chan_master | input | NCH | Per-channel master role |
| cont_en | input | NCH | Per-channel continuous-burst option |
| imm_mode | input | 1 | Immediate-start mode |
| burst_field | input | LEN_W | Burst length minus one, in bits |
| xch_wr | input | 1 | Write strobe for the exchange bit |
| xch_wdata | input | 1 | Value written to the exchange bit |
| tc_clr | input | 1 | Clears tc_flag |
| ovf_clr | input | 1 | Clears ovf_flag |
| tx_wr_evt | input | 1 | A word was accepted into the transmit queue |
| tx_empty | input | 1 | Transmit queue empty |
| tx_data | input | 8*WB | Transmit queue head word |
| tx_pop | output | 1 | Pop the transmit head |
| rx_full | input | 1 | Receive queue full |
| rx_push | output | 1 | Push rx_word |
| rx_word | output | 8*WB | Assembled received word |
| bx_valid | output | 1 | Byte offered to the shifter |
| bx_ready | input | 1 | Shifter accepts the byte |
| bx_tx | output | 8 | Byte to send |
| bx_rvalid | input | 1 | Received byte valid |
| bx_rdata | input | 8 | Received byte |
| cs_n | output | NCH | Active-low chip selects |
| xch_bit | output | 1 | Exchange-request bit |
| tc_flag | output | 1 | Transfer-complete flag (sticky) |
| ovf_flag | output | 1 | Receive-overflow flag (sticky) |
| busy | output | 1 | Engine active |

## Verification
The hard case is a start event that arrives in the same cycle as a burst end. The bench provokes it in immediate mode with a one-byte burst length and two words already queued. It watches for the receive push that marks the final cycle of the first burst, and drives a transmit-write event in that same cycle. The behavioural model runs the two bursts back to back. It therefore expects the second queued word to go out with no further event, and the third word to remain queued. A design that drops the event stops after one byte and leaves two words behind.

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int NCH   = 4,
  parameter int LEN_W = 12,
  parameter int WB    = 4,
  parameter int SEL_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic [NCH-1:0]    chan_master,
  input  logic [NCH-1:0]    cont_en,
  input  logic              imm_mode,
  input  logic [LEN_W-1:0]  burst_field,
  input  logic              xch_wr,
  input  logic              xch_wdata,
  input  logic              tc_clr,
  input  logic              ovf_clr,
  input  logic              tx_wr_evt,
  input  logic              tx_empty,
  input  logic [8*WB-1:0]   tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [8*WB-1:0]   rx_word,
  output logic              bx_valid,
  input  logic              bx_ready,
  output logic [7:0]        bx_tx,
  input  logic              bx_rvalid,
  input  logic [7:0]        bx_rdata,
  output logic [NCH-1:0]    cs_n,
  output logic              xch_bit,
  output logic              tc_flag,
  output logic              ovf_flag,
  output logic              busy
);
  localparam int WW    = 8 * WB;
  localparam int REM_W = LEN_W + 2;
  localparam int IDX_W = $clog2(WB) + 1;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_SEND, S_WAIT, S_FIN} st_t;

  st_t                     st;
  logic signed [REM_W-1:0] rem;
  logic [WW-1:0]           sh, acc;
  logic [IDX_W-1:0]        idx, nb;
  logic                    imm_q;

  wire is_master = chan_master[chan_sel];
  wire cont_mode = is_master && !imm_mode && cont_en[chan_sel];
  wire start = is_master && ((imm_mode && tx_wr_evt) ||
                             (imm_mode && !imm_q && !tx_empty) ||
                             (!imm_mode && xch_wr && xch_wdata && !xch_bit));

  wire rem_np = rem[REM_W-1] || (rem == '0);

  logic [REM_W-1:0] blen, rem_eff, rnd;
  logic [IDX_W-1:0] nb_c;
  assign blen    = {2'b00, burst_field} + REM_W'(1);
  assign rem_eff = rem_np ? blen : rem;
  assign rnd     = rem_eff + REM_W'(7);
  assign nb_c    = (rem_eff >= REM_W'(WW)) ? IDX_W'(WB) : IDX_W'(rnd >> 3);

  wire last_byte = (idx + IDX_W'(1)) == nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rem      <= '0;
      sh       <= '0;
      acc      <= '0;
      idx      <= '0;
      nb       <= '0;
      imm_q    <= 1'b0;
      xch_bit  <= 1'b0;
      tc_flag  <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      imm_q <= imm_mode;
      if (xch_wr)  xch_bit  <= xch_wdata;
      if (tc_clr)  tc_flag  <= 1'b0;
      if (ovf_clr) ovf_flag <= 1'b0;
      case (st)
        S_IDLE: if (start) st <= S_CHK;
        S_CHK: begin
          if (tx_empty) begin
            tc_flag <= 1'b1;
            xch_bit <= 1'b0;
            st      <= start ? S_CHK : S_IDLE;
          end else begin
            if (rem_np) begin
              rem <= blen;
              if (cont_mode) xch_bit <= 1'b1;
            end
            sh  <= tx_data;
            acc <= '0;
            idx <= '0;
            nb  <= nb_c;
            st  <= S_SEND;
          end
        end
        S_SEND: if (bx_ready) st <= S_WAIT;
        S_WAIT: if (bx_rvalid) begin
          acc[8*idx +: 8] <= bx_rdata;
          sh  <= sh >> 8;
          rem <= rem - REM_W'(8);
          idx <= idx + IDX_W'(1);
          st  <= last_byte ? S_FIN : S_SEND;
        end
        S_FIN: begin
          if (rx_full) ovf_flag <= 1'b1;
          if (rem_np && !cont_mode) begin
            tc_flag <= 1'b1;
            if (tx_empty) xch_bit <= 1'b0;
            st <= start ? S_CHK : S_IDLE;
          end else begin
            st <= S_CHK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tx_pop   = (st == S_CHK) && !tx_empty;
  assign rx_push  = (st == S_FIN) && !rx_full;
  assign rx_word  = acc;
  assign bx_valid = (st == S_SEND);
  assign bx_tx    = sh[7:0];
  assign busy     = (st != S_IDLE);

  for (genvar g = 0; g < NCH; g++) begin : g_cs
    assign cs_n[g] = !(is_master && (chan_sel == SEL_W'(g)));
  end
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk #(
  parameter int NCH   = 4,
  parameter int SEL_W = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] chan_sel,
  input logic [NCH-1:0]   chan_master,
  input logic [NCH-1:0]   cs_n,
  input logic             bx_valid,
  input logic             bx_ready,
  input logic [7:0]       bx_tx,
  input logic             tx_pop,
  input logic             tx_empty,
  input logic             rx_push,
  input logic             rx_full,
  input logic             busy,
  input logic             xch_bit,
  input logic             tc_flag
);
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    chan_master[chan_sel] |-> ($countones(~cs_n) == 1) && !cs_n[chan_sel]);

  a_r10_none_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_master[chan_sel] |-> (&cs_n));

  a_r2_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_valid && !bx_ready) |=> (bx_valid && $stable(bx_tx)));

  a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  a_r4_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  a_r9_drain_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(tx_empty)) |-> (tc_flag && !xch_bit));
endmodule

bind spi_burst_engine spi_burst_engine_chk #(.NCH(NCH), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .chan_master(chan_master),
  .cs_n(cs_n), .bx_valid(bx_valid), .bx_ready(bx_ready), .bx_tx(bx_tx),
  .tx_pop(tx_pop), .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full),
  .busy(busy), .xch_bit(xch_bit), .tc_flag(tc_flag)
);

// File: tb/spi_burst_engine_tb_top.sv
module spi_burst_engine_tb_top;
  localparam int CLK_P = 10;
  localparam int TXD   = 8;
  localparam int RXD   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  chan_sel = 2'd1;
  logic [3:0]  chan_master = 4'b0010;
  logic [3:0]  cont_en = 4'b0000;
  logic        imm_mode = 1'b0;
  logic [11:0] burst_field = 12'd63;
  logic        xch_wr = 1'b0, xch_wdata = 1'b0;
  logic        tc_clr = 1'b0, ovf_clr = 1'b0;
  logic        tx_wr_evt = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_empty = 1'b1;
  logic [31:0] tx_data = '0;
  logic        tx_pop, rx_push;
  logic        rx_full = 1'b0;
  logic [31:0] rx_word;
  logic        bx_valid, bx_ready = 1'b0;
  logic [7:0]  bx_tx;
  logic        bx_rvalid = 1'b0;
  logic [7:0]  bx_rdata = '0;
  logic [3:0]  cs_n;
  logic        xch_bit, tc_flag, ovf_flag, busy;

  always #(CLK_P/2) clk = ~clk;

  spi_burst_engine dut_i (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .chan_master(chan_master),
    .cont_en(cont_en), .imm_mode(imm_mode), .burst_field(burst_field),
    .xch_wr(xch_wr), .xch_wdata(xch_wdata), .tc_clr(tc_clr), .ovf_clr(ovf_clr),
    .tx_wr_evt(tx_wr_evt), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
    .bx_valid(bx_valid), .bx_ready(bx_ready), .bx_tx(bx_tx),
    .bx_rvalid(bx_rvalid), .bx_rdata(bx_rdata), .cs_n(cs_n),
    .xch_bit(xch_bit), .tc_flag(tc_flag), .ovf_flag(ovf_flag), .busy(busy)
  );

  int n_vec = 0, n_bad = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // transmit queue, receive occupancy and byte shifter
  logic [31:0] txq[$];
  int          rx_cnt = 0;
  logic        rx_drain_req = 1'b0;
  int          cyc = 0, pend = 0;
  logic [7:0]  lastb = '0;

  always @(posedge clk) begin
    if (tx_pop && txq.size() > 0) void'(txq.pop_front());
    if (tx_wr_evt && txq.size() < TXD) txq.push_back(tx_wdata);
    tx_empty <= (txq.size() == 0);
    tx_data  <= (txq.size() > 0) ? txq[0] : 32'h0;
    if (rx_drain_req) begin
      rx_cnt <= 0; rx_full <= 1'b0;
    end else if (rx_push) begin
      rx_cnt <= rx_cnt + 1; rx_full <= (rx_cnt + 1 >= RXD);
    end
    cyc <= cyc + 1;
    bx_ready <= (cyc % 3) != 1;
    if (bx_rvalid) bx_rvalid <= 1'b0;
    if (bx_valid && bx_ready) begin
      lastb <= bx_tx; pend <= 2;
    end else if (pend == 1) begin
      bx_rvalid <= 1'b1; bx_rdata <= ~lastb; pend <= 0;
    end else if (pend > 1) pend <= pend - 1;
  end

  // behavioural model
  logic [31:0] mq[$];
  logic [7:0]  exp_b[$];
  logic [31:0] exp_r[$];
  int          m_rem = 0, m_rxn = 0;
  logic        m_xch = 0, m_tc = 0, m_ovf = 0;

  function automatic logic m_master();
    return chan_master[chan_sel];
  endfunction

  task automatic model_flush();
    int len;
    logic cont;
    len  = int'(burst_field) + 1;
    cont = m_master() && !imm_mode && cont_en[chan_sel];
    while (mq.size() > 0) begin
      logic [31:0] w, acc;
      int b, k;
      if (m_rem <= 0) begin
        m_rem = len;
        if (cont) m_xch = 1'b1;
      end
      w = mq.pop_front();
      b = (m_rem < 32) ? m_rem : 32;
      acc = '0; k = 0;
      while (b > 0) begin
        exp_b.push_back(w[7:0]);
        acc = acc | ({24'h0, ~w[7:0]} << (8 * k));
        w = w >> 8; b -= 8; m_rem -= 8; k++;
      end
      if (m_rxn >= RXD) m_ovf = 1'b1;
      else begin exp_r.push_back(acc); m_rxn++; end
      if (m_rem <= 0 && !cont) begin m_tc = 1'b1; break; end
    end
    if (mq.size() == 0) begin m_tc = 1'b1; m_xch = 1'b0; end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 cs_n", {28'h0, cs_n},
          {28'h0, chan_master[chan_sel] ? ~(4'b0001 << chan_sel) : 4'hF});
      if (bx_valid && bx_ready) begin
        if (exp_b.size() == 0) chk("R2 unexpected byte", {24'h0, bx_tx}, 32'hFFFF_FFFF);
        else chk("R2 byte order", {24'h0, bx_tx}, {24'h0, exp_b.pop_front()});
      end
      if (rx_push) begin
        if (exp_r.size() == 0) chk("R3 unexpected rx word", rx_word, 32'hFFFF_FFFF);
        else chk("R3 rx word", rx_word, exp_r.pop_front());
      end
    end
  end

  task automatic push_word(input logic [31:0] w, input bit run);
    if (mq.size() < TXD) mq.push_back(w);
    if (run && imm_mode && m_master()) model_flush();
    @(negedge clk); tx_wdata = w; tx_wr_evt = 1'b1;
    @(negedge clk); tx_wr_evt = 1'b0;
  endtask

  task automatic xch_write(input logic v);
    logic rise;
    rise = v && !m_xch;
    m_xch = v;
    if (rise && !imm_mode && m_master()) model_flush();
    @(negedge clk); xch_wr = 1'b1; xch_wdata = v;
    @(negedge clk); xch_wr = 1'b0;
  endtask

  task automatic set_imm(input logic v);
    if (v && !imm_mode && mq.size() > 0 && m_master()) begin
      imm_mode = v; model_flush();
    end
    @(negedge clk); imm_mode = v;
  endtask

  task automatic clr_tc();
    m_tc = 0;
    @(negedge clk); tc_clr = 1'b1;
    @(negedge clk); tc_clr = 1'b0;
  endtask

  task automatic drain_rx();
    m_rxn = 0;
    @(negedge clk); rx_drain_req = 1'b1;
    @(negedge clk); rx_drain_req = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic end_check(input string r);
    chk({r, " bytes left"}, exp_b.size(), 0);
    chk({r, " words left"}, exp_r.size(), 0);
    chk({r, " tx count"}, txq.size(), mq.size());
    chk({r, " tc_flag"}, tc_flag, m_tc);
    chk({r, " ovf_flag"}, ovf_flag, m_ovf);
    chk({r, " xch_bit"}, xch_bit, m_xch);
    chk({r, " busy"}, busy, 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run hung, actual=busy expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy, 0);
    chk("R12 tc_flag", tc_flag, 0);
    chk("R12 ovf_flag", ovf_flag, 0);
    chk("R12 xch_bit", xch_bit, 0);
    chk("R12 bx_valid", bx_valid, 0);

    // R6/R1/R9: request mode, 64-bit burst over two words, drains
    push_word(32'h4433_2211, 0);
    push_word(32'h8877_6655, 0);
    repeat (4) @(negedge clk);
    chk("R6 no start before request", txq.size(), 2);
    xch_write(1);
    wait_idle();
    end_check("R9");
    drain_rx();

    // R8: 12-bit bursts stop with words left; R12 tc clear
    burst_field = 12'd11;
    clr_tc();
    push_word(32'hA1B2_C3D4, 0);
    push_word(32'h1020_3040, 0);
    push_word(32'h5566_7788, 0);
    xch_write(1);
    wait_idle();
    end_check("R8");
    clr_tc();
    chk("R12 tc cleared", tc_flag, 0);
    xch_write(0); xch_write(1);
    wait_idle();
    end_check("R1");
    xch_write(0); xch_write(1);
    wait_idle();
    end_check("R9 second");
    drain_rx();

    // R7: continuous mode runs through 16-bit burst ends
    cont_en = 4'b0010;
    burst_field = 12'd15;
    clr_tc();
    push_word(32'h0F0E_0D0C, 0);
    push_word(32'h1B1A_1918, 0);
    push_word(32'h2726_2524, 0);
    xch_write(1);
    wait_idle();
    end_check("R7");
    cont_en = 4'b0000;
    drain_rx();

    // R5: immediate mode, 40-bit burst, start on each write
    burst_field = 12'd39;
    set_imm(1);
    clr_tc();
    push_word(32'hCAFE_F00D, 1);
    wait_idle();
    end_check("R5 first");
    push_word(32'h0000_00E7, 1);
    wait_idle();
    end_check("R5 second");
    drain_rx();

    // R5: turning immediate mode on with queued words starts
    set_imm(0);
    clr_tc();
    push_word(32'h1357_9BDF, 0);
    push_word(32'h2468_ACE0, 0);
    repeat (4) @(negedge clk);
    chk("R5 write in request mode idle", txq.size(), 2);
    set_imm(1);
    wait_idle();
    end_check("R5 rise");
    drain_rx();

    // R11: start event in the burst-end cycle
    burst_field = 12'd7;
    set_imm(0);
    clr_tc();
    push_word(32'h0000_0031, 0);
    push_word(32'h0000_0032, 0);
    set_imm(1);
    do @(negedge clk); while (!rx_push);
    mq.push_back(32'h0000_0033);
    model_flush();
    tx_wdata = 32'h0000_0033; tx_wr_evt = 1'b1;
    @(negedge clk); tx_wr_evt = 1'b0;
    wait_idle();
    end_check("R11");
    drain_rx();

    // R4: overflow with a 256-bit burst, queue holds 4 words
    set_imm(0);
    burst_field = 12'd255;
    clr_tc();
    for (int i = 0; i < 6; i++) push_word(32'h1111_1111 * (i + 1), 0);
    xch_write(1);
    wait_idle();
    end_check("R4");
    @(negedge clk); ovf_clr = 1'b1; m_ovf = 0;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R4 ovf cleared", ovf_flag, 0);
    drain_rx();

    // R10/R6: non-master channel, request only stored
    chan_sel = 2'd2;
    clr_tc();
    push_word(32'hDEAD_0001, 0);
    xch_write(1);
    repeat (8) @(negedge clk);
    chk("R10 no start on slave channel", busy, 0);
    end_check("R6 stored");
    xch_write(0);

    // R10: channel 3 as master, drains the waiting word
    chan_sel = 2'd3;
    chan_master = 4'b1000;
    burst_field = 12'd31;
    xch_write(1);
    wait_idle();
    end_check("R10 ch3");
    drain_rx();

    finish_run();
  end
endmodule